// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block gives a memory controller a small set of hardware performance counters. Four counters sit behind a memory-mapped register port. Counter 0 is a free-running cycle counter. Counters 1 to 3 each watch one bit of a per-cycle event pulse vector, and an 8-bit code in their control register picks that bit. Software programs a counter by writing its control register, then reads the count whenever it likes. Reads never disturb the count.

The cycle counter is the master gate for the whole unit. While it is disabled, no counter advances. When it wraps, every counter freezes and a level interrupt goes high. The interrupt stays high until software writes counter 0's control register. An event counter that wraps sets its own overflow flag and keeps counting, without raising the interrupt.

The register port uses a request channel and a read-response channel, both valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A read returns its data on the response channel one cycle later, and that data holds until `rsp_ready` accepts it. Only one read can be outstanding. `req_ready` stays low while a response waits, so a stalled response back-pressures the request side. Writes produce no response.

Top module: `pcu_top`

## Requirements
- R1: After reset, every control register, every count register and the word at 0x30 read 0, and `irq` is low.
- R2: While counter 0 is enabled and not frozen, its count advances by one on every clock edge. Counting starts on the first edge after the write that enables it.
- R3: Counters 1 to 3 advance at most once per cycle, on cycles where bit `code[5:0]` of `event_in` is high. Here `code` is control bits 31:24. A code of 64 or above counts nothing.
- R4: Counter 0 counts cycles whatever code its control register holds. The stored code still reads back.
- R5: A counter among 1 to 3 does not advance while counter 0 is disabled, even if the counter itself is enabled.
- R6: A control write with bit 1 (clear) set zeroes the count on that same edge, even if an increment was due then. Bit 1 always reads back as 0.
- R7: A control write with bit 2 (enable) at 0 stops the counter, and the count holds its value.
- R8: When counter 0 wraps from all ones, it reads 0 and its bit 0 (overflow) is set. `irq` goes high on that edge, and from then on no counter advances.
- R9: `irq` and counter 0's overflow flag stay set until a write to counter 0's control register. Writing 0 there clears both. Writing enable with clear then restarts all counting.
- R10: When counter 1, 2 or 3 wraps, it continues from 0 and sets its own overflow bit 0. `irq` does not change.
- R11: The control register of counter n sits at byte 4*n and its count register at 0x20+4*n. Count registers are read-only, and writes to them are dropped. The word at 0x30 is plain read/write storage. Any other address reads 0.
- R12: A read response holds `rsp_valid` and `rsp_rdata` stable until `rsp_ready` is high. `req_ready` is low whenever a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data consumer ready |
| rsp_rdata | output | 32 | Read data |
| event_in | input | EV_W (64) | Per-cycle event pulses |
| irq | output | 1 | Level interrupt, high after cycle counter wrap |

## Verification
Most internal errors in this block show up as a count value that is off by a known number of cycles. The bench therefore reads the cycle count against the exact edge the read was accepted, and it pulses events in counted bursts. A wrong gate, a late clear or a lost freeze shows up at the first count read after the fault, usually within tens of cycles. An overflow fault shows up on the exact edge where `irq` should rise. A frozen counter that still moves is caught by two reads taken fifty cycles apart.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 8;
  // register map (neighbouring software decodes these)
  localparam int CTRL_BASE  = 'h00;
  localparam int COUNT_BASE = 'h20;
  localparam int AUX_OFF    = 'h30;
  // control word field positions
  localparam int BIT_OVF    = 0;
  localparam int BIT_CLR    = 1;
  localparam int BIT_EN     = 2;
  localparam int SEL_LSB    = 24;

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic en, input logic ovf,
                                                  input logic [SEL_W-1:0] sel);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_OVF] = ovf;
    w[BIT_EN]  = en;
    w[SEL_LSB +: SEL_W] = sel;
    return w;
  endfunction
endpackage

// File: rtl/pcu_evsel.sv
module pcu_evsel #(
  parameter int EV_W     = 64,
  parameter int SEL_W    = 8,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [EV_W-1:0]  events,
  output logic             hit
);
  localparam int IDX_W = $clog2(EV_W);

  generate
    if (IS_CYCLE) begin : g_cycle
      logic unused_in;
      assign unused_in = ^{sel, events};
      assign hit = 1'b1;
    end else begin : g_event
      logic in_range;
      assign in_range = (int'(sel) < EV_W);
      assign hit = in_range & events[sel[IDX_W-1:0]];
    end
  endgenerate
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
  import pcu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EV_W     = 64,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run,
  input  logic [EV_W-1:0]   events,
  output logic [CNT_W-1:0]  count,
  output logic              enabled,
  output logic              ovf,
  output logic [DATA_W-1:0] ctrl_word
);
  logic [SEL_W-1:0] sel;
  logic             hit;
  logic             inc;
  logic             wrap;
  logic             unused_bits;

  assign unused_bits = ^{wdata[SEL_LSB-1:BIT_EN+1], wdata[BIT_OVF]};

  pcu_evsel #(.EV_W(EV_W), .SEL_W(SEL_W), .IS_CYCLE(IS_CYCLE)) u_evsel (
    .sel    (sel),
    .events (events),
    .hit    (hit)
  );

  assign inc  = enabled & run & hit;
  assign wrap = inc & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      sel     <= '0;
    end else if (wr) begin
      enabled <= wdata[BIT_EN];
      sel     <= wdata[SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr && wdata[BIT_CLR]) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (wr) begin
      ovf <= 1'b0;
    end else if (wrap) begin
      ovf <= 1'b1;
    end
  end

  assign ctrl_word = pack_ctrl(enabled, ovf, sel);
endmodule

// File: rtl/pcu_regif.sv
module pcu_regif
  import pcu_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = 32,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [AW-1:0]       req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [N-1:0]        ctrl_wr,
  input  logic [N*DATA_W-1:0] ctrl_rd_flat,
  input  logic [N*CNT_W-1:0]  cnt_flat
);
  logic              accept;
  logic              aux_wr;
  logic [DATA_W-1:0] aux_q;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;

  always_comb begin
    ctrl_wr = '0;
    for (int i = 0; i < N; i++) begin
      if (accept && req_we && req_addr == AW'(CTRL_BASE + 4*i)) ctrl_wr[i] = 1'b1;
    end
  end

  assign aux_wr = accept & req_we & (req_addr == AW'(AUX_OFF));

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N; i++) begin
      if (req_addr == AW'(CTRL_BASE + 4*i))  rd_mux = ctrl_rd_flat[i*DATA_W +: DATA_W];
      if (req_addr == AW'(COUNT_BASE + 4*i)) rd_mux = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
    end
    if (req_addr == AW'(AUX_OFF)) rd_mux = aux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= '0;
    else if (aux_wr) aux_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_we) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = 32,
  parameter int EV_W  = 64,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [EV_W-1:0]   event_in,
  output logic              irq
);
  logic [N-1:0]        ctrl_wr;
  logic [N-1:0]        en_vec;
  logic [N-1:0]        ovf_vec;
  logic [N*DATA_W-1:0] ctrl_rd_flat;
  logic [N*CNT_W-1:0]  cnt_flat;
  logic                run_all;

  // counter 0 gates everything: disabled or wrapped stops the whole unit
  assign run_all = en_vec[0] & ~ovf_vec[0];
  assign irq     = ovf_vec[0];

  pcu_regif #(.N(N), .CNT_W(CNT_W), .AW(AW)) u_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .ctrl_wr      (ctrl_wr),
    .ctrl_rd_flat (ctrl_rd_flat),
    .cnt_flat     (cnt_flat)
  );

  for (genvar i = 0; i < N; i++) begin : g_cnt
    pcu_counter #(.CNT_W(CNT_W), .EV_W(EV_W), .IS_CYCLE(i == 0)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctrl_wr[i]),
      .wdata     (req_wdata),
      .run       (run_all),
      .events    (event_in),
      .count     (cnt_flat[i*CNT_W +: CNT_W]),
      .enabled   (en_vec[i]),
      .ovf       (ovf_vec[i]),
      .ctrl_word (ctrl_rd_flat[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int N     = 4,
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [31:0]        rsp_rdata,
  input logic               irq,
  input logic [N-1:0]       ctrl_wr,
  input logic [N-1:0]       en_vec,
  input logic [N*CNT_W-1:0] cnt_flat
);
  logic [CNT_W-1:0] cyc_cnt;
  assign cyc_cnt = cnt_flat[CNT_W-1:0];

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(|ctrl_wr) |=> $stable(cnt_flat));

  a_r8_wrap_raises: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cyc_cnt == '0) && ($past(cyc_cnt) == '1));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ctrl_wr[0] |=> irq);

  a_r5_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_vec[0] && !(|ctrl_wr) |=> $stable(cnt_flat));
endmodule

bind pcu_top pcu_checker #(.N(N), .CNT_W(CNT_W)) u_pcu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .ctrl_wr   (ctrl_wr),
  .en_vec    (en_vec),
  .cnt_flat  (cnt_flat)
);

// File: tb/test_pcu_top.sv
module test_pcu_top;
  localparam int CW = 12;
  localparam logic [31:0] MASK = 32'h0000_0FFF;
  localparam int WRAP = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [63:0] event_in = '0;
  logic        irq;

  always #10 clk = ~clk;

  pcu_top #(.CNT_W(CW)) i_pcu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .event_in(event_in), .irq(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as each response is taken
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      exp_t e;
      if (sbq.size() == 0) chk(1'b0, "R12 unexpected response", rsp_rdata, 32'h0);
      else begin
        e = sbq.pop_front();
        chk(rsp_rdata === e.val, e.tag, rsp_rdata, e.val);
      end
    end
  end

  // driver: cyc_mode expectations are add + (accept edge - base - 1)
  task automatic issue(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input bit cyc_mode, input int base, input logic [31:0] add,
                       input string tag, output int acc);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    if (!we) begin
      e.tag = tag;
      e.val = cyc_mode ? ((add + 32'(acc - base - 1)) & MASK) : add;
      sbq.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int acc);
    issue(1'b1, a, d, 1'b0, 0, 32'h0, "", acc);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    int acc;
    issue(1'b0, a, 32'h0, 1'b0, 0, exp, tag, acc);
  endtask

  task automatic rdc(input logic [7:0] a, input int base, input logic [31:0] add, input string tag);
    int acc;
    issue(1'b0, a, 32'h0, 1'b1, base, add, tag, acc);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    finish_run();
  end

  initial begin
    int a0, a1, w0, w1, e1, e2;
    logic [31:0] frz;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq low after reset", 32'(irq), 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), 32'h0, "R1 ctrl reset");
      rd(8'('h20 + 4*i), 32'h0, "R1 count reset");
    end
    rd(8'h30, 32'h0, "R1 aux reset");

    // R11 map: aux storage, read-only counts, unmapped
    wr(8'h30, 32'hA5A5_1234, a1);
    rd(8'h30, 32'hA5A5_1234, "R11 aux read back");
    wr(8'h24, 32'h0000_0055, a1);
    rd(8'h24, 32'h0, "R11 count write ignored");
    rd(8'h3C, 32'h0, "R11 unmapped reads zero");

    // R5 counter 1 enabled, counter 0 off: no counting
    wr(8'h04, 32'h0400_0006, a1);
    @(negedge clk) event_in[4] = 1'b1;
    idle(10);
    event_in[4] = 1'b0;
    rd(8'h24, 32'h0, "R5 stalled without cycle counter");

    // R2 cycle counting
    wr(8'h00, 32'h0000_0006, a0);
    idle(5);
    rdc(8'h20, a0, 32'h0, "R2 cycle count");
    idle(17);
    rdc(8'h20, a0, 32'h0, "R2 cycle count later");

    // R3 event selection on three counters
    wr(8'h04, 32'h0, a1);
    wr(8'h04, 32'h0400_0006, a1);
    wr(8'h08, 32'h0500_0006, a1);
    wr(8'h0C, 32'h3700_0006, a1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      event_in = '0;
      event_in[4]  = (i % 3 == 0);
      event_in[5]  = (i % 5 == 0);
      event_in[55] = (i < 2);
    end
    @(negedge clk) event_in = '0;
    rd(8'h24, 32'd7, "R3 code 0x04 pulses");
    rd(8'h28, 32'd4, "R3 code 0x05 pulses");
    rd(8'h2C, 32'd2, "R3 code 0x37 pulses");
    rd(8'h04, 32'h0400_0004, "R6 clear bit reads zero");
    wr(8'h0C, 32'h4400_0006, a1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) event_in[4] = 1'b1;
      @(negedge clk) event_in[4] = 1'b0;
    end
    rd(8'h2C, 32'h0, "R3 code 0x44 out of range");

    // R4 counter 0 ignores its code
    wr(8'h00, 32'h0, a1);
    wr(8'h00, 32'h2100_0006, a0);
    idle(9);
    rdc(8'h20, a0, 32'h0, "R4 cycles with code 0x21");
    rd(8'h00, 32'h2100_0004, "R4 code stored");

    // R7 disable holds value
    wr(8'h08, 32'h0, a1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) event_in[5] = 1'b1;
      @(negedge clk) event_in[5] = 1'b0;
    end
    rd(8'h28, 32'd4, "R7 disabled counter holds");

    // R6 clear wins over a due increment
    @(negedge clk) event_in[4] = 1'b1;
    idle(3);
    wr(8'h04, 32'h0400_0006, e1);
    idle(6);
    rdc(8'h24, e1, 32'h0, "R6 clear priority");
    event_in[4] = 1'b0;

    // R10 silent wrap of counter 1
    wr(8'h00, 32'h0, a1);
    wr(8'h00, 32'h0000_0006, a0);
    @(negedge clk) event_in[4] = 1'b1;
    wr(8'h04, 32'h0400_0006, e1);
    idle(3000);
    wr(8'h00, 32'h0, w0);
    wr(8'h00, 32'h0000_0006, w1);
    idle(1200);
    rdc(8'h24, e1, 32'(-(w1 - w0)), "R10 counter 1 wrapped");
    rd(8'h04, 32'h0400_0005, "R10 overflow bit set");
    chk(irq == 1'b0, "R10 no interrupt", 32'(irq), 32'h0);
    @(negedge clk) event_in[4] = 1'b0;

    // R8 cycle counter wrap freezes all
    wr(8'h00, 32'h0, a1);
    wr(8'h00, 32'h0000_0006, a0);
    @(negedge clk) event_in[5] = 1'b1;
    wr(8'h08, 32'h0500_0006, e2);
    while (!irq && cyc < a0 + WRAP + 100) @(negedge clk);
    chk(cyc == a0 + WRAP, "R8 irq rise edge", 32'(cyc), 32'(a0 + WRAP));
    rd(8'h20, 32'h0, "R8 count0 wrapped");
    rd(8'h00, 32'h0000_0005, "R8 ctrl0 overflow");
    frz = 32'(a0 + WRAP - e2) & MASK;
    rd(8'h28, frz, "R8 counter 2 at freeze");
    idle(50);
    rd(8'h28, frz, "R8 counter 2 frozen");
    rd(8'h20, 32'h0, "R8 count0 frozen");
    chk(irq == 1'b1, "R9 irq held", 32'(irq), 32'h1);

    // R9 release and restart
    wr(8'h00, 32'h0, a1);
    chk(irq == 1'b0, "R9 irq cleared by write", 32'(irq), 32'h0);
    rd(8'h00, 32'h0, "R9 ctrl0 cleared");
    rd(8'h28, frz, "R9 still stopped");
    wr(8'h00, 32'h0000_0006, a0);
    idle(10);
    rdc(8'h28, a0, frz, "R9 counting resumes");
    @(negedge clk) event_in = '0;

    // R12 back-pressure on the response
    wr(8'h30, 32'hCAFE_0001, a1);
    @(negedge clk) rsp_ready = 1'b0;
    rd(8'h30, 32'hCAFE_0001, "R12 held response data");
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid && !req_ready && rsp_rdata == 32'hCAFE_0001,
          "R12 response held under back-pressure", rsp_rdata, 32'hCAFE_0001);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    rd(8'h00, 32'h0000_0004, "R12 next read after release");

    while (sbq.size() != 0) @(negedge clk);
    idle(2);
    finish_run();
  end
endmodule